// File: doc/BRIEF.md
# Isolated I/O Register Bank

This block is a byte-wide register bank for a digital I/O card with sixteen output drivers and sixteen isolated inputs. A host reaches it through a plain register port: a 3-bit address, 8-bit write data, a write strobe and a read strobe, with the read result returned one clock later. Two 8-bit latches drive the outputs. Two 8-bit input ports are synchronized, optionally debounced, and watched for a change of level in either direction. A change sets a pending flag, which drives a level-high interrupt line while interrupts are enabled.

Several registers act through the side effects of an access. Reading the interrupt-control register enables the interrupt, and writing it disables it. Reading the filter-control register switches the input debounce on for all sixteen inputs, and writing it switches the debounce off. Writing the low input register clears the pending interrupt. A write never carries meaning through its data on these registers. The host port is a register interface with no flow control: every strobe is taken in the cycle it is presented, and there is no back-pressure.

Top module: `iso_io_bank`

## Requirements
- R1: A write to address 0 loads `drv_lo`, and a write to address 4 loads `drv_hi`, both from `wdata` on the next clock. A read of either address returns the latched value.
- R2: A read of address 1 returns the conditioned level of `pin_lo`, and a read of address 5 returns that of `pin_hi`. With the debounce off, a pin level present before rising edge k is the conditioned level from edge k+2 on.
- R3: An accepted read of address 2 enables the interrupt. A write to address 2 disables it, whatever the data.
- R4: An accepted read of address 3 turns the debounce on, and a write to address 3 turns it off. While the debounce is on, a new pin level is accepted only after 4 consecutive clock samples at the synchronizer output, so a pulse held for 3 clocks is dropped and one held for 4 is taken. While the debounce is off, a pulse of 1 clock is taken.
- R5: A change of conditioned level, rising or falling, latches the pending status. A read of address 6 returns a status byte laid out as follows: bit 0 marks a change on `pin_lo`, bit 1 marks a change on `pin_hi`, bit 2 is set while either of those bits is set, and bits 7:3 are zero.
- R6: A write to address 1 clears all three status bits, whatever the data. A change detected in the same cycle as the clear still sets its bit.
- R7: `irq` is high exactly when a status bit is pending and the interrupt is enabled. Changes are latched while the interrupt is disabled.
- R8: Writes to addresses 5, 6 and 7 change no state. Reads of addresses 2, 3 and 7 return 0.
- R9: `rdata` updates only on the clock edge of an accepted read and holds otherwise. When both strobes are high together, only the write is performed, and the read and its side effect are ignored.
- R10: After reset, both output latches are 0, the interrupt and the debounce are off, no status bit is set, and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| rdata | output | 8 | Read data, valid the cycle after the read |
| pin_lo | input | 8 | Isolated inputs 0-7, asynchronous |
| pin_hi | input | 8 | Isolated inputs 8-15, asynchronous |
| drv_lo | output | 8 | Output drivers 0-7 |
| drv_hi | output | 8 | Output drivers 8-15 |
| irq | output | 1 | Interrupt request, level high |

## Verification
The assertions assume that `addr` and `wdata` are known whenever a strobe is high. They also assume that each strobe-high clock is one separate access, so a strobe held for two clocks counts as two reads or two writes, each with its side effect. They make no assumption about when the pins move, because the pins pass through the synchronizer before any checked logic sees them. The stimulus changes every input only at falling clock edges and always holds defined values. Its random phase mixes reads, writes and simultaneous strobes to all eight addresses with single-bit pin toggles, including toggles made while the debounce is being switched on and off.

// File: rtl/iso_io_pkg.sv
package iso_io_pkg;
  localparam int ADDR_W = 3;

  // register map; the host software depends on these offsets
  localparam logic [ADDR_W-1:0] A_DRV_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_IN_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IRQ    = 3'd2;
  localparam logic [ADDR_W-1:0] A_FILT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DRV_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_IN_HI  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd6;

  // status byte bit positions
  localparam int STAT_LO  = 0;
  localparam int STAT_HI  = 1;
  localparam int STAT_ANY = 2;
endpackage

// File: rtl/iso_in_cond.sv
// Per-lane synchronizer, optional debounce and change detector.
module iso_in_cond #(
  parameter int W        = 16,
  parameter int FILT_LEN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         filt_en,
  input  logic [W-1:0] pin,
  output logic [W-1:0] level,
  output logic [W-1:0] toggle
);
  localparam int CW = $clog2(FILT_LEN);

  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pin;
      s2 <= s1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_lane
    logic          lvl, lvl_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // cnt counts consecutive samples that disagree with the accepted level
    always_comb begin
      lvl_nxt = lvl;
      cnt_nxt = '0;
      if (!filt_en) begin
        lvl_nxt = s2[i];
      end else if (s2[i] != lvl) begin
        if (cnt == CW'(FILT_LEN - 1)) lvl_nxt = s2[i];
        else                          cnt_nxt = cnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl <= 1'b0;
        cnt <= '0;
      end else begin
        lvl <= lvl_nxt;
        cnt <= cnt_nxt;
      end
    end

    assign level[i]  = lvl;
    assign toggle[i] = lvl_nxt ^ lvl;
  end
endmodule

// File: rtl/iso_irq_ctl.sv
// Pending-change flags per input port and interrupt enable.
module iso_irq_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*DW-1:0] toggle,
  input  logic          clr,
  input  logic          en_set,
  input  logic          en_clr,
  output logic [1:0]    src,
  output logic          irq
);
  logic       en;
  logic [1:0] hit;

  assign hit = {|toggle[2*DW-1:DW], |toggle[DW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      en  <= 1'b0;
    end else begin
      // a change in the clearing cycle is kept
      src <= (clr ? 2'b00 : src) | hit;
      if (en_clr)      en <= 1'b0;
      else if (en_set) en <= 1'b1;
    end
  end

  assign irq = (|src) & en;
endmodule

// File: rtl/iso_io_bank.sv
module iso_io_bank
  import iso_io_pkg::*;
#(
  parameter int DW       = 8,
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     pin_lo,
  input  logic [DW-1:0]     pin_hi,
  output logic [DW-1:0]     drv_lo,
  output logic [DW-1:0]     drv_hi,
  output logic              irq
);
  localparam int NIN = 2 * DW;

  logic            rd_ok;
  logic            filt_en;
  logic [NIN-1:0]  level, toggle;
  logic [1:0]      src;
  logic [DW-1:0]   rsel;
  logic            pend_any, chg_any;

  // a write takes precedence; a read in the same cycle is dropped
  assign rd_ok = rd_en & ~wr_en;

  iso_in_cond #(.W(NIN), .FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en),
    .pin({pin_hi, pin_lo}), .level(level), .toggle(toggle)
  );

  iso_irq_ctl #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .toggle(toggle),
    .clr(wr_en && addr == A_IN_LO),
    .en_set(rd_ok && addr == A_IRQ),
    .en_clr(wr_en && addr == A_IRQ),
    .src(src), .irq(irq)
  );

  assign pend_any = |src;
  assign chg_any  = |toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_lo  <= '0;
      drv_hi  <= '0;
      filt_en <= 1'b0;
    end else begin
      if (wr_en && addr == A_DRV_LO) drv_lo <= wdata;
      if (wr_en && addr == A_DRV_HI) drv_hi <= wdata;
      if (wr_en && addr == A_FILT)      filt_en <= 1'b0;
      else if (rd_ok && addr == A_FILT) filt_en <= 1'b1;
    end
  end

  always_comb begin
    rsel = '0;
    case (addr)
      A_DRV_LO: rsel = drv_lo;
      A_DRV_HI: rsel = drv_hi;
      A_IN_LO:  rsel = level[DW-1:0];
      A_IN_HI:  rsel = level[NIN-1:DW];
      A_STAT: begin
        rsel[STAT_LO]  = src[0];
        rsel[STAT_HI]  = src[1];
        rsel[STAT_ANY] = pend_any;
      end
      default:  rsel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_ok) rdata <= rsel;
  end
endmodule

// File: rtl/iso_io_chk.sv
module iso_io_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    addr,
  input logic [DW-1:0] wdata,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] drv_lo,
  input logic [DW-1:0] drv_hi,
  input logic          irq,
  input logic          pend,
  input logic          chg_any
);
  assert_drv_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> drv_lo == $past(wdata));

  assert_drv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (addr != 3'd0 && addr != 3'd4)) |=> ($stable(drv_lo) && $stable(drv_hi)));

  assert_irq_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> !irq);

  assert_irq_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 3'd2 && pend) |=> irq);

  assert_stat_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 3'd6) |=>
      (rdata[DW-1:3] == '0 && rdata[2] == (rdata[1] | rdata[0])));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !chg_any) |=> !irq);

  assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_any |=> pend);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> $stable(rdata));
endmodule

bind iso_io_bank iso_io_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
  .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
  .drv_lo(drv_lo), .drv_hi(drv_hi), .irq(irq),
  .pend(pend_any), .chg_any(chg_any)
);

// File: tb/sim_iso_io_bank.sv
module sim_iso_io_bank;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata, pin_lo = '0, pin_hi = '0, drv_lo, drv_hi;
  logic       irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_io_bank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .pin_lo(pin_lo), .pin_hi(pin_hi),
    .drv_lo(drv_lo), .drv_hi(drv_hi), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [15:0] hist [6];     // pin samples, [0] newest
  logic [15:0] m_acc;
  logic [1:0]  m_src;
  logic        m_en, m_filt;
  logic [7:0]  m_lo, m_hi, m_rd;
  string       m_tag = "R10";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < 6; j++) hist[j] = '0;
      m_acc = '0; m_src = '0; m_en = 0; m_filt = 0;
      m_lo = '0; m_hi = '0; m_rd = '0; m_tag = "R10";
    end else begin
      logic [15:0] nacc, chg;
      logic        rd_take;
      for (int j = 5; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = {pin_hi, pin_lo};
      nacc = m_acc;
      for (int b = 0; b < 16; b++) begin
        if (!m_filt) nacc[b] = hist[2][b];
        else if (hist[2][b] == hist[3][b] && hist[3][b] == hist[4][b] &&
                 hist[4][b] == hist[5][b] && hist[2][b] != m_acc[b])
          nacc[b] = hist[2][b];
      end
      chg = nacc ^ m_acc;
      rd_take = rd_en && !wr_en;
      if (rd_take) begin
        case (addr)
          3'd0: begin m_rd = m_lo; m_tag = "R1"; end
          3'd4: begin m_rd = m_hi; m_tag = "R1"; end
          3'd1: begin m_rd = m_acc[7:0]; m_tag = "R2"; end
          3'd5: begin m_rd = m_acc[15:8]; m_tag = "R2"; end
          3'd6: begin m_rd = {5'b0, |m_src, m_src}; m_tag = "R5"; end
          default: begin m_rd = 8'h00; m_tag = "R8"; end
        endcase
        if (addr == 3'd2) m_en = 1;
        if (addr == 3'd3) m_filt = 1;
      end
      if (wr_en) begin
        case (addr)
          3'd0: m_lo = wdata;
          3'd4: m_hi = wdata;
          3'd1: m_src = '0;
          3'd2: m_en = 0;
          3'd3: m_filt = 0;
          default: ;
        endcase
      end
      if (|chg[7:0])  m_src[0] = 1'b1;
      if (|chg[15:8]) m_src[1] = 1'b1;
      m_acc = nacc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 drv_lo", drv_lo, m_lo);
      chk("R1 drv_hi", drv_hi, m_hi);
      chk("R7 irq", {7'b0, irq}, {7'b0, (|m_src) & m_en});
      chk({m_tag, " rdata"}, rdata, m_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; rd_en = 0;
    end
  endtask

  task automatic pins(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk);
    wr_en = 0; rd_en = 0; pin_lo = lo; pin_hi = hi;
  endtask

  // hold pin_lo at val for exactly n rising edges, then restore
  task automatic pulse_lo(input logic [7:0] val, input int n);
    logic [7:0] back;
    back = pin_lo;
    pins(val, pin_hi);
    for (int i = 1; i < n; i++) @(negedge clk);
    pins(back, pin_hi);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    chk("R10 drv_lo", drv_lo, 8'h00);
    chk("R10 drv_hi", drv_hi, 8'h00);
    chk("R10 irq", {7'b0, irq}, 8'h00);
    chk("R10 rdata", rdata, 8'h00);
    bus(0, 1, 3'd6, 8'h00); idle(1);
    chk("R10 status", rdata, 8'h00);

    bus(1, 0, 3'd0, 8'hA5); bus(1, 0, 3'd4, 8'h3C);
    bus(0, 1, 3'd0, 8'h00); idle(1); chk("R1 read lo", rdata, 8'hA5);
    bus(0, 1, 3'd4, 8'h00); idle(1); chk("R1 read hi", rdata, 8'h3C);

    bus(1, 0, 3'd5, 8'hFF); bus(1, 0, 3'd6, 8'hFF); bus(1, 0, 3'd7, 8'hFF); idle(1);
    chk("R8 drv_lo kept", drv_lo, 8'hA5);
    chk("R8 drv_hi kept", drv_hi, 8'h3C);
    bus(0, 1, 3'd7, 8'h00); idle(1); chk("R8 read 7", rdata, 8'h00);

    pins(8'h08, 8'h00); idle(4);
    bus(0, 1, 3'd6, 8'h00); idle(1);
    chk("R5 status lo rise", rdata, 8'h05);
    chk("R7 latched while disabled", {7'b0, irq}, 8'h00);
    bus(0, 1, 3'd1, 8'h00); idle(1); chk("R2 level lo", rdata, 8'h08);

    bus(0, 1, 3'd2, 8'h00); idle(1);
    chk("R3 read enables", {7'b0, irq}, 8'h01);
    chk("R8 read 2", rdata, 8'h00);
    bus(1, 0, 3'd1, 8'h00); idle(1);
    chk("R6 clear", {7'b0, irq}, 8'h00);
    bus(0, 1, 3'd6, 8'h00); idle(1); chk("R6 status cleared", rdata, 8'h00);

    pins(8'h08, 8'h80); idle(4);
    chk("R5 irq hi rise", {7'b0, irq}, 8'h01);
    bus(0, 1, 3'd6, 8'h00); idle(1); chk("R5 status hi rise", rdata, 8'h06);
    bus(1, 0, 3'd1, 8'h5A);
    pins(8'h08, 8'h00); idle(4);
    bus(0, 1, 3'd6, 8'h00); idle(1); chk("R5 status hi fall", rdata, 8'h06);
    bus(0, 1, 3'd5, 8'h00); idle(1); chk("R2 level hi", rdata, 8'h00);
    bus(1, 0, 3'd1, 8'h00);
    bus(1, 0, 3'd2, 8'hFF); idle(1);
    chk("R3 write disables", {7'b0, irq}, 8'h00);

    bus(1, 1, 3'd0, 8'h5A); idle(1);
    chk("R9 write wins", drv_lo, 8'h5A);
    chk("R9 read dropped", rdata, 8'h00);

    bus(1, 0, 3'd1, 8'h00);
    bus(0, 1, 3'd3, 8'h00); idle(2);
    pulse_lo(8'h09, 3); idle(8);
    bus(0, 1, 3'd6, 8'h00); idle(1); chk("R4 3-clock pulse dropped", rdata, 8'h00);
    pulse_lo(8'h09, 4); idle(8);
    bus(0, 1, 3'd6, 8'h00); idle(1); chk("R4 4-clock pulse taken", rdata, 8'h05);
    bus(1, 0, 3'd1, 8'h00);
    bus(1, 0, 3'd3, 8'h00); idle(2);
    pulse_lo(8'h09, 1); idle(4);
    bus(0, 1, 3'd6, 8'h00); idle(1); chk("R4 unfiltered 1-clock pulse", rdata, 8'h05);

    // mixed traffic, compared against the reference every clock
    for (int c = 0; c < 2000; c++) begin
      int op;
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pin_lo = pin_lo ^ (8'h01 << $urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) pin_hi = pin_hi ^ (8'h01 << $urandom_range(0, 7));
      op = $urandom_range(0, 9);
      addr  = 3'($urandom_range(0, 7));
      wdata = 8'($urandom_range(0, 255));
      wr_en = (op <= 2) || (op == 6);
      rd_en = (op >= 3 && op <= 6);
    end
    idle(10);
    summary();
    $finish;
  end
endmodule